// File: doc/BRIEF.md
# Converter Offset and Gain Calibration Sequencer

This controller sits between the raw result stream of a sigma-delta converter core and the output data register. It decides what the core's input is connected to: the external signal, an internal ground, or the internal reference. It counts the "conversion settled" strobes that the decimation filter issues, once per output period. From the strobes it either captures a zero-scale or full-scale coefficient, or publishes a corrected result. The correction is `out = (raw - zero) * 2^W / (full - zero)`, and it saturates at both ends of the code range.

A host issues calibration commands by writing a mode code. Calibration commands clear themselves when their sequence completes. A background mode interleaves calibration steps with signal conversions and runs until the host writes a new command. The host can read both coefficients at any time and can overwrite them, for example to impose a fixed offset. An active-low ready line falls each time a result or a completion is available. After a calibration command it can remain low for up to one output period before it rises. Completion is therefore recognised by a falling edge that follows a rise.

Top module: `offset_gain_cal`

## Requirements
- R1: After reset the mode readback is 0, the input select is signal (00), ready_n is 1, dout is 0, the zero coefficient is 0 and the full coefficient is all-ones.
- R2: After reset, and after any return to normal mode (code 0, or the end of a calibration), the first SETTLE-1 strobes are discarded with ready_n high. Every later strobe loads dout and drives ready_n low on the edge that samples the strobe.
- R3: A normal result equals floor((raw-zero)*2^W/(full-zero)). It is forced to 0 when raw <= zero and to all-ones when the quotient exceeds the maximum code.
- R4: When full <= zero, the correction is bypassed and dout equals raw.
- R5: Self calibration (code 1) drives the select to ground (01) for SETTLE+1 strobes and captures the last raw value as zero. It then drives the select to reference (10) for SETTLE strobes and captures the last value as full, for 2*SETTLE+1 strobes in total.
- R6: When any calibration (codes 1 to 4) finishes, the mode readback returns to 0, ready_n goes low and the select returns to signal. After the command is accepted, ready_n keeps its level until the first strobe, which drives it high.
- R7: Code 2 (external zero step) and code 3 (external gain step) keep the select on signal for SETTLE+1 strobes. Code 2 captures the last value into zero and code 3 captures it into full.
- R8: Code 4 (gain step of the external-offset calibration) holds the select on reference for SETTLE+1 strobes and captures the last value into full.
- R9: Background mode (code 5) repeats four steps of BG_STEP strobes each: ground capturing zero, signal producing a result, reference capturing full, and signal producing a result. This gives one result per 2*BG_STEP strobes. The mode readback stays 5.
- R10: With bg_zero_only high, the third background step uses ground and captures zero, and full is left unchanged.
- R11: A command written while a calibration of codes 1 to 4 is running is ignored, so the mode readback and the select are unchanged.
- R12: A host write with coef_sel 0 replaces zero and a write with coef_sel 1 replaces full. Both values are visible on the readback ports on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_mode | input | 3 | Mode code (0 normal, 1 self, 2 ext zero, 3 ext gain, 4 ref gain, 5 background) |
| bg_zero_only | input | 1 | Background mode recalibrates zero only |
| settled | input | 1 | Filter result valid strobe, one per output period |
| raw_data | input | W | Raw filter result |
| coef_we | input | 1 | Host coefficient write |
| coef_sel | input | 1 | 0 selects zero, 1 selects full |
| coef_wdata | input | W | Host coefficient value |
| in_sel | output | 2 | Core input select: 00 signal, 01 ground, 10 reference |
| mode_rd | output | 3 | Command field readback, auto-cleared |
| coef_zero_rd | output | W | Zero-scale coefficient |
| coef_full_rd | output | W | Full-scale coefficient |
| dout | output | W | Corrected result |
| ready_n | output | 1 | Active-low data ready |

## Verification
The correction is swept over every raw code of an 8-bit configuration after a self calibration. The sweep separates the linear region from the clamps at zero and at all-ones. Host-written coefficient pairs check the scale factor against an independent quotient and check the bypass taken when the full coefficient is at or below the zero coefficient. Each calibration code is driven with distinct raw values on the capture strobe and on the strobes before it. This shows which strobe is captured, which coefficient receives it, and where the select points. The background pattern is run both with and without the zero-only option, to tell the reference step from a repeated ground step.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    M_NORMAL = 3'd0,
    M_SELF   = 3'd1,
    M_EXTZ   = 3'd2,
    M_EXTG   = 3'd3,
    M_REFG   = 3'd4,
    M_BG     = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    SEL_SIG = 2'b00,
    SEL_GND = 2'b01,
    SEL_REF = 2'b10
  } sel_e;

  typedef enum logic [1:0] {
    PH_NORM,
    PH_ZERO,
    PH_FULL,
    PH_BG
  } phase_e;
endpackage

// File: rtl/cal_coef_store.sv
module cal_coef_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_zero,
  input  logic         cap_full,
  input  logic [W-1:0] cap_data,
  input  logic         host_we,
  input  logic         host_sel,
  input  logic [W-1:0] host_data,
  output logic [W-1:0] zero_q,
  output logic [W-1:0] full_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q <= '0;
      full_q <= '1;
    end else begin
      if (cap_zero)                 zero_q <= cap_data;
      else if (host_we && !host_sel) zero_q <= host_data;
      if (cap_full)                 full_q <= cap_data;
      else if (host_we && host_sel)  full_q <= host_data;
    end
  end
endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  logic [W-1:0] zero,
  input  logic [W-1:0] full,
  output logic [W-1:0] corr
);
  localparam int QW = 2 * W;

  logic [W:0]    diff;
  logic [W:0]    span;
  logic [QW-1:0] num;
  logic [QW-1:0] den;
  logic [QW-1:0] quo;

  always_comb begin
    diff = {1'b0, raw} - {1'b0, zero};
    span = {1'b0, full} - {1'b0, zero};
    num  = {diff[W-1:0], {W{1'b0}}};
    den  = {{W{1'b0}}, span[W-1:0]};
    quo  = (den == '0) ? '0 : num / den;
    if (span[W] || span == '0)      corr = raw;
    else if (diff[W] || diff == '0) corr = '0;
    else if (|quo[QW-1:W])          corr = '1;
    else                            corr = quo[W-1:0];
  end
endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
  import cal_pkg::*;
#(
  parameter int SETTLE  = 4,
  parameter int BG_STEP = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic [2:0] cmd_mode,
  input  logic       bg_zero_only,
  input  logic       settled,
  output logic [2:0] mode_q,
  output logic [1:0] sel_q,
  output logic       rdy_n_q,
  output logic       cap_zero,
  output logic       cap_full,
  output logic       load_out
);
  localparam int MAXC = (SETTLE > BG_STEP) ? SETTLE : BG_STEP;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LIM_LONG  = CW'(SETTLE);
  localparam logic [CW-1:0] LIM_SHORT = CW'(SETTLE - 1);
  localparam logic [CW-1:0] LIM_BG    = CW'(BG_STEP - 1);

  phase_e        phase_q;
  logic          chain_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [1:0]    bg_idx_q;
  logic [1:0]    bg_next;
  logic          busy, accept, at_end, strobe;

  function automatic logic [1:0] bg_sel(input logic [1:0] idx, input logic zonly);
    case (idx)
      2'd0:    bg_sel = SEL_GND;
      2'd2:    bg_sel = zonly ? SEL_GND : SEL_REF;
      default: bg_sel = SEL_SIG;
    endcase
  endfunction

  always_comb begin
    busy     = (phase_q == PH_ZERO) || (phase_q == PH_FULL);
    accept   = cmd_we && !busy;
    at_end   = (cnt_q == lim_q);
    strobe   = settled && !accept && at_end;
    bg_next  = bg_idx_q + 2'd1;
    cap_zero = 1'b0;
    cap_full = 1'b0;
    load_out = 1'b0;
    case (phase_q)
      PH_NORM: load_out = strobe;
      PH_ZERO: cap_zero = strobe;
      PH_FULL: cap_full = strobe;
      default: begin
        if (strobe) begin
          if (bg_idx_q[0])                  load_out = 1'b1;
          else if (bg_idx_q == 2'd0 || bg_zero_only) cap_zero = 1'b1;
          else                              cap_full = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_NORM;
      mode_q   <= M_NORMAL;
      sel_q    <= SEL_SIG;
      rdy_n_q  <= 1'b1;
      cnt_q    <= '0;
      lim_q    <= LIM_SHORT;
      chain_q  <= 1'b0;
      bg_idx_q <= '0;
    end else if (accept) begin
      cnt_q    <= '0;
      chain_q  <= 1'b0;
      bg_idx_q <= '0;
      mode_q   <= (cmd_mode <= 3'd5) ? cmd_mode : M_NORMAL;
      case (cmd_mode)
        M_SELF: begin phase_q <= PH_ZERO; chain_q <= 1'b1; sel_q <= SEL_GND; lim_q <= LIM_LONG; end
        M_EXTZ: begin phase_q <= PH_ZERO; sel_q <= SEL_SIG; lim_q <= LIM_LONG; end
        M_EXTG: begin phase_q <= PH_FULL; sel_q <= SEL_SIG; lim_q <= LIM_LONG; end
        M_REFG: begin phase_q <= PH_FULL; sel_q <= SEL_REF; lim_q <= LIM_LONG; end
        M_BG:   begin phase_q <= PH_BG;   sel_q <= SEL_GND; lim_q <= LIM_BG;   end
        default: begin phase_q <= PH_NORM; sel_q <= SEL_SIG; lim_q <= LIM_SHORT; end
      endcase
    end else if (settled) begin
      if (!at_end) begin
        cnt_q   <= cnt_q + 1'b1;
        rdy_n_q <= 1'b1;
      end else begin
        case (phase_q)
          PH_NORM: rdy_n_q <= 1'b0;
          PH_BG: begin
            cnt_q    <= '0;
            bg_idx_q <= bg_next;
            sel_q    <= bg_sel(bg_next, bg_zero_only);
            rdy_n_q  <= ~bg_idx_q[0];
          end
          default: begin
            if (phase_q == PH_ZERO && chain_q) begin
              phase_q <= PH_FULL;
              chain_q <= 1'b0;
              sel_q   <= SEL_REF;
              lim_q   <= LIM_SHORT;
              cnt_q   <= '0;
              rdy_n_q <= 1'b1;
            end else begin
              phase_q <= PH_NORM;
              sel_q   <= SEL_SIG;
              lim_q   <= LIM_SHORT;
              cnt_q   <= '0;
              mode_q  <= M_NORMAL;
              rdy_n_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/offset_gain_cal.sv
module offset_gain_cal #(
  parameter int W       = 16,
  parameter int SETTLE  = 4,
  parameter int BG_STEP = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_we,
  input  logic [2:0]   cmd_mode,
  input  logic         bg_zero_only,
  input  logic         settled,
  input  logic [W-1:0] raw_data,
  input  logic         coef_we,
  input  logic         coef_sel,
  input  logic [W-1:0] coef_wdata,
  output logic [1:0]   in_sel,
  output logic [2:0]   mode_rd,
  output logic [W-1:0] coef_zero_rd,
  output logic [W-1:0] coef_full_rd,
  output logic [W-1:0] dout,
  output logic         ready_n
);
  logic         cap_zero, cap_full, load_out;
  logic [W-1:0] corr;

  cal_seq_fsm #(.SETTLE(SETTLE), .BG_STEP(BG_STEP)) u_fsm (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_mode(cmd_mode),
    .bg_zero_only(bg_zero_only), .settled(settled),
    .mode_q(mode_rd), .sel_q(in_sel), .rdy_n_q(ready_n),
    .cap_zero(cap_zero), .cap_full(cap_full), .load_out(load_out)
  );

  cal_coef_store #(.W(W)) u_coef (
    .clk(clk), .rst(rst), .cap_zero(cap_zero), .cap_full(cap_full),
    .cap_data(raw_data), .host_we(coef_we), .host_sel(coef_sel),
    .host_data(coef_wdata), .zero_q(coef_zero_rd), .full_q(coef_full_rd)
  );

  cal_corrector #(.W(W)) u_corr (
    .raw(raw_data), .zero(coef_zero_rd), .full(coef_full_rd), .corr(corr)
  );

  always_ff @(posedge clk) begin
    if (rst)           dout <= '0;
    else if (load_out) dout <= corr;
  end
endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_we,
  input logic         settled,
  input logic [2:0]   mode_rd,
  input logic [1:0]   in_sel,
  input logic         ready_n,
  input logic [W-1:0] dout
);
  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !settled && mode_rd != 3'd0 && mode_rd != 3'd5) |=> $stable(mode_rd));

  p_ready_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_n) |-> $past(settled));

  p_sel_code_r5: assert property (@(posedge clk) disable iff (rst)
    in_sel != 2'b11);

  p_self_not_sig_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_rd == 3'd1) |-> (in_sel != 2'b00));

  p_dout_with_ready_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> !ready_n);

  p_autoclear_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_rd) != 3'd0 && $past(mode_rd) != 3'd5 && mode_rd == 3'd0) |-> !ready_n);
endmodule

bind offset_gain_cal cal_seq_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .settled(settled),
  .mode_rd(mode_rd), .in_sel(in_sel), .ready_n(ready_n), .dout(dout)
);

// File: tb/sim_offset_gain_cal.sv
module sim_offset_gain_cal;
  localparam int CLK_NS = 10;
  localparam int W = 8;
  localparam int SETTLE = 4;
  localparam int BG_STEP = 3;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_we = 1'b0;
  logic [2:0]   cmd_mode = '0;
  logic         bg_zero_only = 1'b0;
  logic         settled = 1'b0;
  logic [W-1:0] raw_data = '0;
  logic         coef_we = 1'b0;
  logic         coef_sel = 1'b0;
  logic [W-1:0] coef_wdata = '0;
  logic [1:0]   in_sel;
  logic [2:0]   mode_rd;
  logic [W-1:0] coef_zero_rd, coef_full_rd, dout;
  logic         ready_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  int ez, ef;

  offset_gain_cal #(.W(W), .SETTLE(SETTLE), .BG_STEP(BG_STEP)) u0 (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_mode(cmd_mode),
    .bg_zero_only(bg_zero_only), .settled(settled), .raw_data(raw_data),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
    .in_sel(in_sel), .mode_rd(mode_rd), .coef_zero_rd(coef_zero_rd),
    .coef_full_rd(coef_full_rd), .dout(dout), .ready_n(ready_n)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int model(int r, int z, int f);
    int q;
    if (f <= z) return r;
    if (r <= z) return 0;
    q = ((r - z) * (1 << W)) / (f - z);
    return (q > MAXV) ? MAXV : q;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int r);
    @(negedge clk);
    raw_data = W'(r);
    settled = 1'b1;
    @(negedge clk);
    settled = 1'b0;
  endtask

  task automatic command(input int m);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_mode = 3'(m);
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic host_write(input bit s, input int v);
    @(negedge clk);
    coef_we = 1'b1;
    coef_sel = s;
    coef_wdata = W'(v);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic purge();
    for (int i = 0; i < SETTLE - 1; i++) begin
      strobe(3);
      check(ready_n == 1'b1, "R2 purge ready_n", ready_n, 1);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mode_rd == 0, "R1 mode", mode_rd, 0);
    check(in_sel == 2'b00, "R1 sel", in_sel, 0);
    check(ready_n == 1, "R1 ready_n", ready_n, 1);
    check(dout == 0, "R1 dout", dout, 0);
    check(coef_zero_rd == 0, "R1 zero", coef_zero_rd, 0);
    check(coef_full_rd == MAXV, "R1 full", coef_full_rd, MAXV);

    // R2 normal start-up purge then output
    purge();
    strobe(100);
    check(ready_n == 0, "R2 ready_n low", ready_n, 0);
    check(dout == model(100, 0, MAXV), "R3 reset coef result", dout, model(100, 0, MAXV));

    // R5/R6 self calibration
    command(1);
    check(mode_rd == 1, "R5 mode", mode_rd, 1);
    check(in_sel == 2'b01, "R5 ground", in_sel, 1);
    check(ready_n == 0, "R6 ready held", ready_n, 0);
    strobe(99);
    check(ready_n == 1, "R6 ready rises", ready_n, 1);
    strobe(98);
    command(5);
    check(mode_rd == 1, "R11 mode kept", mode_rd, 1);
    check(in_sel == 2'b01, "R11 sel kept", in_sel, 1);
    strobe(97);
    strobe(96);
    strobe(10);
    check(coef_zero_rd == 10, "R5 zero capture", coef_zero_rd, 10);
    check(in_sel == 2'b10, "R5 reference", in_sel, 2);
    for (int i = 0; i < SETTLE - 1; i++) begin
      strobe(150 + i);
      check(ready_n == 1 && mode_rd == 1, "R6 busy", ready_n, 1);
    end
    strobe(210);
    check(coef_full_rd == 210, "R5 full capture", coef_full_rd, 210);
    check(mode_rd == 0, "R6 autoclear", mode_rd, 0);
    check(ready_n == 0, "R6 ready low", ready_n, 0);
    check(in_sel == 2'b00, "R6 sel signal", in_sel, 0);

    // R3 full sweep
    purge();
    for (int r = 0; r <= MAXV; r++) begin
      strobe(r);
      check(dout == model(r, 10, 210) && ready_n == 0, "R3 sweep", dout, model(r, 10, 210));
    end

    // R12 host coefficients
    host_write(0, 20);
    host_write(1, 120);
    check(coef_zero_rd == 20, "R12 zero write", coef_zero_rd, 20);
    check(coef_full_rd == 120, "R12 full write", coef_full_rd, 120);
    strobe(70);
    check(dout == 128, "R12 host result", dout, 128);
    strobe(200);
    check(dout == MAXV, "R3 upper clamp", dout, MAXV);

    // R4 bypass
    host_write(0, 200);
    host_write(1, 100);
    strobe(77);
    check(dout == 77, "R4 bypass", dout, 77);
    host_write(1, 200);
    strobe(33);
    check(dout == 33, "R4 equal bypass", dout, 33);

    // R7 external zero and gain steps
    command(2);
    check(in_sel == 2'b00 && mode_rd == 2, "R7 zero step sel", in_sel, 0);
    for (int i = 0; i < SETTLE; i++) strobe(60 + i);
    check(mode_rd == 2, "R7 still busy", mode_rd, 2);
    strobe(30);
    check(coef_zero_rd == 30 && coef_full_rd == 200, "R7 zero capture", coef_zero_rd, 30);
    check(mode_rd == 0 && ready_n == 0, "R7 zero done", mode_rd, 0);
    command(3);
    check(in_sel == 2'b00 && mode_rd == 3, "R7 gain step sel", mode_rd, 3);
    for (int i = 0; i < SETTLE; i++) strobe(90 + i);
    strobe(230);
    check(coef_full_rd == 230 && coef_zero_rd == 30, "R7 full capture", coef_full_rd, 230);
    purge();
    strobe(130);
    check(dout == 128, "R7 system result", dout, 128);

    // R8 reference gain step
    command(4);
    check(in_sel == 2'b10 && mode_rd == 4, "R8 ref sel", in_sel, 2);
    for (int i = 0; i < SETTLE; i++) strobe(50);
    strobe(240);
    check(coef_full_rd == 240 && mode_rd == 0, "R8 full capture", coef_full_rd, 240);

    // R9 background
    ez = 30; ef = 240;
    command(5);
    check(in_sel == 2'b01, "R9 step0 ground", in_sel, 1);
    for (int i = 0; i < BG_STEP - 1; i++) strobe(1);
    strobe(5); ez = 5;
    check(coef_zero_rd == 5 && ready_n == 1 && in_sel == 2'b00, "R9 zero step", coef_zero_rd, 5);
    for (int i = 0; i < BG_STEP - 1; i++) strobe(9);
    check(ready_n == 1, "R9 no early data", ready_n, 1);
    strobe(105);
    check(dout == model(105, ez, ef) && ready_n == 0, "R9 first result", dout, model(105, ez, ef));
    check(in_sel == 2'b10, "R9 reference step", in_sel, 2);
    for (int i = 0; i < BG_STEP - 1; i++) strobe(2);
    strobe(205); ef = 205;
    check(coef_full_rd == 205 && coef_zero_rd == 5, "R9 full step", coef_full_rd, 205);
    for (int i = 0; i < BG_STEP - 1; i++) strobe(9);
    strobe(105);
    check(dout == 128 && ready_n == 0, "R9 second result", dout, 128);
    check(mode_rd == 5 && in_sel == 2'b01, "R9 repeats", mode_rd, 5);

    // R10 zero-only background
    bg_zero_only = 1'b1;
    command(5);
    for (int i = 0; i < BG_STEP; i++) strobe(8);
    ez = 8;
    for (int i = 0; i < BG_STEP; i++) strobe(108);
    check(dout == model(108, ez, ef), "R10 first result", dout, model(108, ez, ef));
    check(in_sel == 2'b01, "R10 ground step", in_sel, 1);
    for (int i = 0; i < BG_STEP; i++) strobe(12);
    ez = 12;
    check(coef_zero_rd == 12 && coef_full_rd == 205, "R10 full kept", coef_full_rd, 205);
    for (int i = 0; i < BG_STEP; i++) strobe(112);
    check(dout == model(112, ez, ef), "R10 second result", dout, model(112, ez, ef));

    command(0);
    check(mode_rd == 0 && in_sel == 2'b00, "R2 back to normal", mode_rd, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule